// File: doc/BRIEF.md
# Keyed Configuration Write Protector

This block holds a bank of generic configuration registers behind a small register port with separate write and read addresses. A protection switch decides whether those registers accept writes. Software can flip the switch only by writing a fixed 24-bit password in the same word as the new switch value. Any other password leaves the switch as it was.

While protection is on, a write aimed at a guarded register is dropped. A sticky status word records that a blocked write happened and which register offset it targeted. Reading the status word returns its contents and empties it. If a new blocked write arrives in the same cycle as that read, the new record wins and is kept.

Address map, in word offsets, with N = `NUM_REGS`:
- Offsets 0 to N-1 are the guarded registers.
- Offset N is the mode word.
- Offset N+1 is the status word.
- Any higher offset is unmapped.

Top module: `keyed_write_protector`

## Requirements
- R1: After reset, protection is off, the mode word and status word both read 0, and every guarded register reads 0.
- R2: While protection is off, a write to guarded offset k (0 to N-1) stores the 32-bit data, and a later read of offset k returns it.
- R3: A write to the mode word (offset N) whose bits 31:8 equal 0x534D43 loads protection-enable from data bit 0.
- R4: A write to the mode word with any other value in bits 31:8 leaves protection-enable unchanged, whether the write tries to set it or clear it.
- R5: The mode word reads back as protection-enable in bit 0 and zero in every other bit, so the key field always reads 0.
- R6: While protection is on, a write to a guarded register is discarded and the register keeps its previous value.
- R7: A discarded write sets the status flag (bit 0) and loads the source field (bits 23:8) with the targeted offset; a later discarded write overwrites the source.
- R8: Reading the status word (offset N+1) returns its current value, and from the next cycle on the status word reads 0.
- R9: When a discarded write and a status read occur in the same cycle, the read returns the old value and the status word then holds the new violation.
- R10: Writes to the status word and to unmapped offsets change nothing and are never logged. Unmapped offsets read 0. A mode-word write while protection is on is not logged.
- R11: `rd_data` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | ADDR_W | Word offset of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; a read of the status word clears it |
| rd_addr | input | ADDR_W | Word offset of the read |
| rd_data | output | 32 | Read data for `rd_addr`, valid in the same cycle as `rd_en` |

## Verification
The bench builds the block with `NUM_REGS = 5`. That gives a 3-bit address with the mode word at 5, the status word at 6 and a single unmapped offset at 7. The last guarded offset therefore sits right next to the mode word, and the unmapped path can be reached with a few writes. Reading the status word while a blocked write lands in the same cycle is only possible because reads and writes have separate address ports, and the bench drives exactly that case.

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int          DATA_W   = 32;
    localparam int          KEY_W    = 24;
    localparam int          SRC_W    = 16;
    localparam logic [23:0] UNLOCK_KEY = 24'h534D43;
endpackage

// File: rtl/wp_guard_bank.sv
module wp_guard_bank
    import wp_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int ADDR_W   = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic                             protect,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [DATA_W-1:0]                rd_val,
    output logic                             rd_hit,
    output logic                             blocked
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  wr_hit;

    always_comb begin
        bank_d = bank_q;
        wr_hit = 1'b0;
        rd_val = '0;
        rd_hit = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_addr == ADDR_W'(i)) begin
                wr_hit = 1'b1;
                if (wr_en && !protect) begin
                    bank_d.regs[i] = wr_data;
                end
            end
            if (rd_addr == ADDR_W'(i)) begin
                rd_hit = 1'b1;
                rd_val = bank_q.regs[i];
            end
        end
        blocked = wr_en && protect && wr_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    // R6
    blocked_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && protect) |=> $stable(bank_q));

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_open_chk
        // R2
        open_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !protect && wr_addr == ADDR_W'(g)) |=> bank_q.regs[g] == $past(wr_data));
    end
endmodule

// File: rtl/wp_mode_ctrl.sv
module wp_mode_ctrl
    import wp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [KEY_W-1:0] key,
    input  logic             en_bit,
    output logic             protect
);
    typedef struct packed {
        logic en;
    } mode_t;

    mode_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (upd && key == UNLOCK_KEY) begin
            mode_d.en = en_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign protect = mode_q.en;

    // R3
    key_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && key == UNLOCK_KEY) |=> protect == $past(en_bit));

    // R4
    bad_key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && key != UNLOCK_KEY) |=> $stable(protect));
endmodule

// File: rtl/wp_violation_log.sv
module wp_violation_log
    import wp_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              viol,
    input  logic [ADDR_W-1:0] viol_src,
    input  logic              clr,
    output logic              flag,
    output logic [SRC_W-1:0]  src
);
    typedef struct packed {
        logic             flag;
        logic [SRC_W-1:0] src;
    } log_t;

    log_t log_d, log_q;

    always_comb begin
        log_d = log_q;
        if (viol) begin
            log_d.flag = 1'b1;
            log_d.src  = SRC_W'(viol_src);
        end else if (clr) begin
            log_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            log_q <= '0;
        end else begin
            log_q <= log_d;
        end
    end

    assign flag = log_q.flag;
    assign src  = log_q.src;

    // R7
    viol_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> flag && src == SRC_W'($past(viol_src)));

    // R8
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !viol) |=> !flag && src == '0);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !viol) |=> $stable(flag) && $stable(src));
endmodule

// File: rtl/keyed_write_protector.sv
module keyed_write_protector
    import wp_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int ADDR_W  = $clog2(NUM_REGS + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(NUM_REGS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(NUM_REGS + 1);

    logic              protect;
    logic              blocked;
    logic              bank_rd_hit;
    logic [31:0]       bank_rd_val;
    logic              stat_flag;
    logic [SRC_W-1:0]  stat_src;
    logic              mode_upd;
    logic              stat_clr;

    assign mode_upd = wr_en && (wr_addr == MODE_A);
    assign stat_clr = rd_en && (rd_addr == STAT_A);

    wp_guard_bank #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .protect (protect),
        .rd_addr (rd_addr),
        .rd_val  (bank_rd_val),
        .rd_hit  (bank_rd_hit),
        .blocked (blocked)
    );

    wp_mode_ctrl mode_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (mode_upd),
        .key     (wr_data[31:8]),
        .en_bit  (wr_data[0]),
        .protect (protect)
    );

    wp_violation_log #(
        .ADDR_W (ADDR_W)
    ) log_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .viol     (blocked),
        .viol_src (wr_addr),
        .clr      (stat_clr),
        .flag     (stat_flag),
        .src      (stat_src)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (bank_rd_hit) begin
                rd_data = bank_rd_val;
            end else if (rd_addr == MODE_A) begin
                rd_data = {31'd0, protect};
            end else if (rd_addr == STAT_A) begin
                rd_data = {8'd0, stat_src, 7'd0, stat_flag};
            end
        end
    end

    // R11
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == '0);

    // R10
    mode_not_logged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_upd |-> !blocked);
endmodule

// File: tb/keyed_write_protector_tb_top.sv
module keyed_write_protector_tb_top;
    localparam int NR = 5;
    localparam int AW = $clog2(NR + 2);
    localparam logic [AW-1:0] MODE = AW'(NR);
    localparam logic [AW-1:0] STAT = AW'(NR + 1);
    localparam logic [AW-1:0] UNMAP = AW'(NR + 2);
    localparam logic [31:0] KEYW = 32'h534D4300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    keyed_write_protector #(.NUM_REGS(NR)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [AW-1:0] wa, input logic [31:0] wd,
                       input logic re, input logic [AW-1:0] ra, output logic [31:0] rdv);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = ra;
        #1 rdv = rd_data;
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0; wr_addr = '0; rd_addr = '0; wr_data = '0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        cyc(1'b1, a, d, 1'b0, '0, dummy);
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
        cyc(1'b0, '0, '0, 1'b1, a, v);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(MODE, v);   check("R1 mode", v, 32'h0);
        rd(STAT, v);   check("R1 status", v, 32'h0);
        for (int i = 0; i < NR; i++) begin
            rd(AW'(i), v); check("R1 reg", v, 32'h0);
        end
    endtask

    task automatic t_open_write();
        logic [31:0] v;
        for (int i = 0; i < NR; i++) wr(AW'(i), 32'hA5000000 + 32'(i * 17));
        for (int i = 0; i < NR; i++) begin
            rd(AW'(i), v); check("R2 readback", v, 32'hA5000000 + 32'(i * 17));
        end
        @(negedge clk);
        rd_addr = AW'(1);
        #1 check("R11 idle read", rd_data, 32'h0);
        rd_addr = '0;
    endtask

    task automatic t_key();
        logic [31:0] v;
        wr(MODE, 32'h534D4401);
        rd(MODE, v); check("R4 bad key set", v, 32'h0);
        wr(MODE, 32'h00000001);
        rd(MODE, v); check("R4 zero key set", v, 32'h0);
        wr(MODE, KEYW | 32'h1);
        rd(MODE, v); check("R3 R5 enable", v, 32'h1);
    endtask

    task automatic t_blocked();
        logic [31:0] v;
        wr(AW'(2), 32'hDEADBEEF);
        rd(AW'(2), v); check("R6 kept", v, 32'hA5000022);
        rd(STAT, v);   check("R7 status", v, 32'h00000201);
        rd(STAT, v);   check("R8 cleared", v, 32'h0);
        wr(AW'(1), 32'h1); wr(AW'(NR - 1), 32'h2);
        rd(AW'(NR - 1), v); check("R6 top reg kept", v, 32'hA5000044);
        rd(STAT, v);   check("R7 overwrite", v, {8'd0, 16'(NR - 1), 8'h01});
        wr(MODE, KEYW | 32'h1);
        rd(STAT, v);   check("R10 mode write not logged", v, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(AW'(1), 32'h55);
        cyc(1'b1, AW'(4), 32'h77, 1'b1, STAT, v);
        check("R9 read returns old", v, 32'h00000101);
        rd(STAT, v); check("R9 new kept", v, 32'h00000401);
        rd(AW'(4), v); check("R6 collide reg kept", v, 32'hA5000044);
    endtask

    task automatic t_misc();
        logic [31:0] v;
        wr(STAT, 32'hFFFFFFFF);
        rd(STAT, v);  check("R10 status write", v, 32'h0);
        wr(UNMAP, 32'h12345678);
        rd(UNMAP, v); check("R10 unmapped read", v, 32'h0);
        rd(STAT, v);  check("R10 unmapped not logged", v, 32'h0);
        wr(MODE, 32'h00000000);
        rd(MODE, v);  check("R4 bad key clear", v, 32'h1);
        wr(MODE, KEYW);
        rd(MODE, v);  check("R3 disable", v, 32'h0);
        wr(AW'(3), 32'hCAFEF00D);
        rd(AW'(3), v); check("R2 after disable", v, 32'hCAFEF00D);
        rd(STAT, v);  check("R7 no log when open", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_open_write();
        t_key();
        t_blocked();
        t_collide();
        t_misc();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #40000;
        fails++;
        checks++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule